// File: doc/BRIEF.md
# Reconfigurable Additive-Multiply Cell

This cell is one slice of a larger arithmetic array. In multiplier configuration it forms the product of two 8-bit operands and adds an 8-bit addend and a 16-bit addend in the same pass. The addition is fused: the AND-gate partial products and both addends are reduced together in a carry-save tree, and that stage is registered as a sum and carry pair. A single fast adder then resolves the pair in a second registered stage. A feedback option replaces the 16-bit addend with the cell's own last result, so a chain of instructions accumulates like a multiply-accumulate unit.

The same fast adder can also be driven straight from the operand pins, so the cell works as one 16-bit adder/subtractor or as two independent 8-bit adder/subtractors. Either of these finishes in one cycle. A 6-bit instruction word chooses the function on every cycle. A valid bit moves through the pipeline with the data. Each result appears once, at the latency of the function that produced it, and it stays on the output until the next result.

Top module: `amm_cell`

## Requirements
- R1: During and after reset, `out_valid` is 0, `result` is 0x0000 and `carry_out` is 2'b00 until the first instruction completes.
- R2: When `inst[5:4]`=00, `inst[3]`=1 and `inst[2]`=0, the cell does an unsigned multiply. If `inst[0]`=1, `result` = (a·b + c + w) mod 2^16 and `carry_out[1]` is bit 16 of that exact sum. `carry_out[0]` is 0. `out_valid` rises exactly two cycles after the edge that accepts the instruction and not one cycle after it.
- R3: With `inst[2]`=1 in multiplier configuration, `a`, `b` and `c` are two's-complement values, `c` is sign-extended and `w` is taken as 16 bits. `result` = (a·b + c + w) mod 2^16 and `carry_out` is 2'b00. The latency is two cycles.
- R4: In multiplier configuration with `inst[1]`=1 and `inst[0]`=1, the `result` value held at the accepting edge replaces `w`. A sequence of such instructions therefore accumulates products onto the previous result.
- R5: In multiplier configuration with `inst[0]`=0, `result` is a·b mod 2^16, and both `c` and `w` have no effect.
- R6: With `inst[5:3]`=000 and `inst[0]`=0, the cell is one 16-bit adder over X = {b,a} and Y = `w`. If `inst[2]`=0 it adds, X+Y. If `inst[2]`=1 it subtracts, X + ~Y + 1. `carry_out[1]` is the carry out of bit 15, so in subtraction 1 means no borrow. `carry_out[0]` is 0. The result appears one cycle after acceptance.
- R7: With `inst[5:3]`=000 and `inst[0]`=1, the cell is two independent 8-bit adders. The low byte of `result` is a ± w[7:0] and the high byte is b ± w[15:8]. No carry passes between the two halves. `carry_out[0]` is the carry of the low half and `carry_out[1]` the carry of the high half. Both halves subtract as operand + ~other + 1. The latency is one cycle.
- R8: An instruction with `inst[5:4]` other than 00 is ignored. It produces no `out_valid`, and `result` and `carry_out` are left unchanged.
- R9: A multiply accepted on one cycle always completes. An adder-configuration instruction accepted on the very next cycle would need the output in the same cycle, so it is dropped and produces no `out_valid`.
- R10: Multiply instructions accepted on consecutive cycles produce their results on consecutive cycles, in order.
- R11: While `out_valid` is 0, `result` and `carry_out` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| inst | input | 6 | Function select word |
| a | input | 8 | Multiplicand; low adder operand byte |
| b | input | 8 | Multiplier; high adder operand byte |
| c | input | 8 | 8-bit addend in multiplier configuration |
| w | input | 16 | 16-bit addend; second adder operand |
| out_valid | output | 1 | Result and carries are new this cycle |
| result | output | 16 | Cell result |
| carry_out | output | 2 | Segment carries (see R2, R6, R7) |

## Verification
The assertions check four things on every cycle. Every accepted multiply raises `out_valid` after exactly two cycles. Every adder instruction that does not collide with a multiply raises it after exactly one. Signed multiplies and 16-bit adds leave the carry bits they do not drive at zero. The outputs hold still whenever `out_valid` is low. The directed scenarios are needed for the arithmetic itself: extreme unsigned and signed values, the isolation between the two split halves, the borrow sense of subtraction, and the accumulation through feedback. They also cover the dropped adder op after a multiply and the ignored non-integer instruction classes.

// File: rtl/amm_cell.sv
module amm_cell #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [5:0]    inst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [2*DW-1:0] w,
  output logic          out_valid,
  output logic [2*DW-1:0] result,
  output logic [1:0]    carry_out
);
  localparam int RW = 2 * DW;
  localparam int TW = RW + 1;
  localparam int NT = DW + 3;

  wire legal   = (inst[5:4] == 2'b00);
  wire is_mul  = in_valid & legal & inst[3];
  wire is_add  = in_valid & legal & ~inst[3];
  wire sgn     = inst[2];
  wire addends = inst[0];
  wire fback   = inst[1];

  logic [TW-1:0] ext_a, ext_c, tmaj;
  logic [TW-1:0] term [NT];
  logic [TW-1:0] cs_s, cs_k;

  always_comb begin
    ext_a = sgn ? {{(TW-DW){a[DW-1]}}, a} : {{(TW-DW){1'b0}}, a};
    ext_c = sgn ? {{(TW-DW){c[DW-1]}}, c} : {{(TW-DW){1'b0}}, c};
    for (int i = 0; i < DW; i++) begin
      if (sgn && i == DW - 1)
        term[i] = b[i] ? ~(ext_a << i) : '0;
      else
        term[i] = b[i] ? (ext_a << i) : '0;
    end
    term[DW]   = addends ? ext_c : '0;
    term[DW+1] = addends ? {1'b0, (fback ? result : w)} : '0;
    term[DW+2] = {{(TW-1){1'b0}}, sgn & b[DW-1]};
    cs_s = term[0];
    cs_k = term[1];
    for (int j = 2; j < NT; j++) begin
      tmaj = (cs_s & cs_k) | (cs_s & term[j]) | (cs_k & term[j]);
      cs_s = cs_s ^ cs_k ^ term[j];
      cs_k = tmaj << 1;
    end
  end

  logic          v1, sg1;
  logic [TW-1:0] s1, k1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      sg1 <= 1'b0;
      s1  <= '0;
      k1  <= '0;
    end else begin
      v1 <= is_mul;
      if (is_mul) begin
        s1  <= cs_s;
        k1  <= cs_k;
        sg1 <= sgn;
      end
    end
  end

  logic [RW-1:0] fx, fy;
  logic          split, cin, hcin, top;
  logic [DW:0]   lo, hi;

  always_comb begin
    fx    = v1 ? s1[RW-1:0] : {b, a};
    fy    = v1 ? k1[RW-1:0] : (inst[2] ? ~w : w);
    split = ~v1 & inst[0];
    cin   = ~v1 & inst[2];
    lo    = {1'b0, fx[DW-1:0]} + {1'b0, fy[DW-1:0]} + {{DW{1'b0}}, cin};
    hcin  = split ? cin : lo[DW];
    hi    = {1'b0, fx[RW-1:DW]} + {1'b0, fy[RW-1:DW]} + {{DW{1'b0}}, hcin};
    top   = s1[RW] ^ k1[RW] ^ hi[DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 2'b00;
    end else if (v1) begin
      out_valid <= 1'b1;
      result    <= {hi[DW-1:0], lo[DW-1:0]};
      carry_out <= {~sg1 & top, 1'b0};
    end else if (is_add) begin
      out_valid <= 1'b1;
      result    <= {hi[DW-1:0], lo[DW-1:0]};
      carry_out <= split ? {hi[DW], lo[DW]} : {hi[DW], 1'b0};
    end else begin
      out_valid <= 1'b0;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(is_mul, 2)) |-> out_valid);

  a_r6_add_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(is_add) && !$past(v1)) |-> out_valid);

  a_r3_signed_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(is_mul && sgn, 2)) |-> (carry_out == 2'b00));

  a_r6_wide_low_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && $past(is_add && !inst[0]) && !$past(v1)) |-> !carry_out[0]);

  a_r8_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(in_valid && !legal) && !$past(is_mul, 2)) |-> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && !out_valid) |-> ($stable(result) && $stable(carry_out)));

endmodule

// File: tb/tb_amm_cell.sv
`timescale 1ns/1ps
module tb_amm_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  inst = 6'd0;
  logic [7:0]  a = 8'd0, b = 8'd0, c = 8'd0;
  logic [15:0] w = 16'd0;
  logic        out_valid;
  logic [15:0] result;
  logic [1:0]  carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [18:0] last = 19'd0;

  localparam logic [5:0] MUL_U  = 6'b001000, MADD_U = 6'b001001, MAC_U = 6'b001011;
  localparam logic [5:0] MUL_S  = 6'b001100, MADD_S = 6'b001101, MAC_S = 6'b001111;
  localparam logic [5:0] ADD16  = 6'b000000, SUB16  = 6'b000100;
  localparam logic [5:0] ADD8   = 6'b000001, SUB8   = 6'b000101;

  amm_cell dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inst(inst),
                .a(a), .b(b), .c(c), .w(w),
                .out_valid(out_valid), .result(result), .carry_out(carry_out));

  always #2.5 clk = ~clk;

  function automatic logic [18:0] obs();
    return {out_valid, carry_out, result};
  endfunction

  function automatic logic [18:0] mul_model(input logic [5:0] i, input logic [7:0] xa, xb, xc,
                                            input logic [15:0] xw, input logic [15:0] prev);
    int s;
    int wv;
    wv = i[1] ? int'(prev) : int'(xw);
    if (i[2]) begin
      s = $signed(xa) * $signed(xb);
      if (i[0]) s = s + $signed(xc) + wv;
      return {1'b1, 2'b00, s[15:0]};
    end
    s = xa * xb;
    if (i[0]) s = s + xc + wv;
    return {1'b1, s[16], 1'b0, s[15:0]};
  endfunction

  function automatic logic [18:0] add_model(input logic [5:0] i, input logic [7:0] xa, xb,
                                            input logic [15:0] xw);
    logic [16:0] r;
    logic [8:0]  lo, hi;
    logic [15:0] y;
    y = i[2] ? ~xw : xw;
    if (!i[0]) begin
      r = {1'b0, xb, xa} + {1'b0, y} + {16'd0, i[2]};
      return {1'b1, r[16], 1'b0, r[15:0]};
    end
    lo = {1'b0, xa} + {1'b0, y[7:0]} + {8'd0, i[2]};
    hi = {1'b0, xb} + {1'b0, y[15:8]} + {8'd0, i[2]};
    return {1'b1, hi[8], lo[8], hi[7:0], lo[7:0]};
  endfunction

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] i, input logic [7:0] xa, xb, xc, input logic [15:0] xw);
    @(negedge clk);
    inst = i; a = xa; b = xb; c = xc; w = xw; in_valid = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mul_case(input string req, input logic [5:0] i, input logic [7:0] xa, xb, xc,
                          input logic [15:0] xw);
    logic [18:0] e;
    e = mul_model(i, xa, xb, xc, xw, last[15:0]);
    drive(i, xa, xb, xc, xw);
    idle();
    chk({req, " not early"}, {18'd0, out_valid}, 19'd0);
    @(negedge clk);
    chk(req, obs(), e);
    last = e;
  endtask

  task automatic add_case(input string req, input logic [5:0] i, input logic [7:0] xa, xb,
                          input logic [15:0] xw);
    logic [18:0] e;
    e = add_model(i, xa, xb, xw);
    drive(i, xa, xb, 8'h5A, xw);
    idle();
    chk(req, obs(), e);
    last = e;
  endtask

  task automatic t_reset();
    chk("R1 reset state", obs(), 19'd0);
  endtask

  task automatic t_unsigned();
    mul_case("R2 unsigned max", MADD_U, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF);
    mul_case("R2 unsigned mid", MADD_U, 8'd200, 8'd3, 8'd17, 16'h1000);
    mul_case("R2 unsigned zero", MADD_U, 8'd0, 8'd0, 8'd0, 16'd0);
  endtask

  task automatic t_signed();
    mul_case("R3 signed min*min", MADD_S, 8'h80, 8'h80, 8'hFF, 16'h0000);
    mul_case("R3 signed min*max", MADD_S, 8'h80, 8'h7F, 8'h80, 16'h0100);
    mul_case("R3 signed product", MUL_S, 8'hFD, 8'h05, 8'h00, 16'h0000);
  endtask

  task automatic t_mul_only();
    mul_case("R5 addends ignored", MUL_U, 8'd13, 8'd7, 8'hEE, 16'hBEEF);
    mul_case("R5 signed addends ignored", MUL_S, 8'hF0, 8'h10, 8'h7F, 16'h7777);
  endtask

  task automatic t_mac();
    mul_case("R4 seed", MADD_U, 8'd10, 8'd10, 8'd0, 16'd0);
    mul_case("R4 accumulate 1", MAC_U, 8'd20, 8'd30, 8'd5, 16'hFFFF);
    mul_case("R4 accumulate 2", MAC_U, 8'd255, 8'd2, 8'd1, 16'h0000);
    mul_case("R4 signed accumulate", MAC_S, 8'hFF, 8'h40, 8'hFE, 16'h1234);
  endtask

  task automatic t_add16();
    add_case("R6 add wrap", ADD16, 8'hFF, 8'hFF, 16'h0001);
    add_case("R6 add plain", ADD16, 8'h34, 8'h12, 16'h1111);
    add_case("R6 sub borrow", SUB16, 8'h34, 8'h12, 16'h1235);
    add_case("R6 sub no borrow", SUB16, 8'h00, 8'h50, 16'h1000);
  endtask

  task automatic t_split();
    add_case("R7 split add isolated", ADD8, 8'hFF, 8'h01, 16'h0101);
    add_case("R7 split sub", SUB8, 8'h10, 8'h05, 16'h0611);
    add_case("R7 split sub mixed", SUB8, 8'h20, 8'h07, 16'h0830);
  endtask

  task automatic t_illegal();
    logic [18:0] keep;
    keep = {1'b0, last[17:0]};
    drive(6'b011000, 8'h11, 8'h22, 8'h33, 16'h4444);
    idle();
    chk("R8 class 01 ignored", obs(), keep);
    @(negedge clk);
    chk("R8 class 01 ignored late", obs(), keep);
    drive(6'b111001, 8'h11, 8'h22, 8'h33, 16'h4444);
    idle();
    @(negedge clk);
    chk("R8 class 11 ignored", obs(), keep);
  endtask

  task automatic t_collision();
    logic [18:0] e;
    e = mul_model(MADD_U, 8'd9, 8'd9, 8'd1, 16'd100, last[15:0]);
    drive(MADD_U, 8'd9, 8'd9, 8'd1, 16'd100);
    drive(ADD16, 8'h01, 8'h00, 8'h00, 16'h0001);
    idle();
    chk("R9 multiply wins", obs(), e);
    @(negedge clk);
    chk("R9 adder op dropped", obs(), {1'b0, e[17:0]});
    last = e;
  endtask

  task automatic t_back_to_back();
    logic [18:0] e1, e2;
    e1 = mul_model(MADD_U, 8'd100, 8'd100, 8'd0, 16'd0, last[15:0]);
    e2 = mul_model(MADD_S, 8'hFF, 8'hFF, 8'h02, 16'h0003, last[15:0]);
    drive(MADD_U, 8'd100, 8'd100, 8'd0, 16'd0);
    drive(MADD_S, 8'hFF, 8'hFF, 8'h02, 16'h0003);
    idle();
    chk("R10 first of pair", obs(), e1);
    @(negedge clk);
    chk("R10 second of pair", obs(), e2);
    last = e2;
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk("R11 outputs hold", obs(), {1'b0, last[17:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_mul_only();
    t_mac();
    t_add16();
    t_split();
    t_illegal();
    t_collision();
    t_back_to_back();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule